// File: doc/BRIEF.md
# Dirty Eviction Write Buffer

This block sits between a write-back cache controller and a 128-bit line-wide memory port. Without it, a miss that evicts a dirty line costs two memory accesses in a row: the old line goes out, then the new line comes in, and only then may the requester continue. Here the block accepts the victim line and its line address into a single-line holding slot and acknowledges at once. The read of the missing line goes to memory next. The held line is written out only after that fill has returned to the cache, so the write overlaps with the processor using the fresh data.

While a line is held, the block compares every incoming request with the held address. A read of that address is answered from the slot, with no memory access. A write to that address replaces the held contents. A write to any other address is a second eviction: it waits until the slot has drained. If no fill follows a capture, a hold timer lets the slot drain on its own after a set number of idle cycles. A status output reports when the slot is empty, so a flush can wait for it.

Both sides use a level request that is held until a one-cycle completion pulse. On the cache side the request carries a write flag. On the memory side there are separate read and write strobes.

Top module: `evict_write_buffer`

## Requirements
- R1: After reset, `up_done`, `dn_rd` and `dn_wr` are low and `wb_empty` is high.
- R2: A write request (`up_we`=1) that arrives while the slot is empty is captured into the slot. It is acknowledged by an `up_done` pulse with no memory access, and `wb_empty` goes low.
- R3: A read request whose address misses the slot is issued to memory as `dn_rd` with that address before the held victim is written. `up_rdata` then returns the memory data, and the victim has not yet been written at that point.
- R4: Once a fill has completed while a line is held, the slot drains: `dn_wr` carries the held address and data, and `wb_empty` rises after `dn_done`.
- R5: A read whose address equals the held address returns the held data, and no memory access is made for it.
- R6: A write whose address equals the held address replaces the held data. The later drain writes the new data.
- R7: A write to a different address while the slot is full waits until the held line has been written to memory, and is then captured.
- R8: If no fill completes after a capture, the slot drains by itself once it has spent HOLD_CYCLES idle cycles with the line held.
- R9: `dn_rd` and `dn_wr` are never high together, and `dn_addr` holds steady while a memory request awaits `dn_done`.
- R10: `up_done` is a single-cycle pulse: it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Cache request, held until `up_done` |
| up_we | input | 1 | 1 = victim or line write, 0 = line read |
| up_addr | input | ADDR_W | Line address of the request |
| up_wdata | input | LINE_W | Line data for a write |
| up_done | output | 1 | One-cycle completion pulse to the cache |
| up_rdata | output | LINE_W | Read data, valid while `up_done` is high |
| dn_rd | output | 1 | Memory read strobe, held until `dn_done` |
| dn_wr | output | 1 | Memory write strobe, held until `dn_done` |
| dn_addr | output | ADDR_W | Memory line address |
| dn_wdata | output | LINE_W | Memory write data |
| dn_done | input | 1 | One-cycle memory completion pulse |
| dn_rdata | input | LINE_W | Memory read data, valid with `dn_done` |
| wb_empty | output | 1 | High when no line is held |

## Verification
The assertions check four things on every cycle: that the memory strobes are exclusive, that the memory address is steady during a pending access, that the completion pulse is one cycle long, and that a write only starts when a line is held and never targets an empty slot. Only the bench scenarios can show the ordering rules. They show that the fill read reaches memory before the victim write, that a second eviction waits behind a drain, and that reads and writes to the held address are absorbed by the slot. They also show, through a bench memory model and a scoreboard of expected read data, that the drained line carries the latest merged data and that the hold timer drains an orphaned line within its window.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FILL  = 2'd1,
        SQ_DRAIN = 2'd2,
        SQ_ACK   = 2'd3
    } sq_state_t;

endpackage

// File: rtl/ewb_store.sv
module ewb_store #(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              merge_en,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LINE_W-1:0] in_data,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [LINE_W-1:0] data,
    output logic              hit
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr_en) begin
            slot_d.valid = 1'b0;
        end
        if (cap_en) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = in_addr;
            slot_d.data  = in_data;
        end
        if (merge_en) begin
            slot_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign addr  = slot_q.addr;
    assign data  = slot_q.data;
    assign hit   = slot_q.valid && (in_addr == slot_q.addr);

    // R2
    cap_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !slot_q.valid);

    // R6
    merge_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |-> slot_q.valid);

endmodule

// File: rtl/ewb_arm_timer.sv
module ewb_arm_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fill_done,
    input  logic line_held,
    input  logic count_en,
    output logic armed
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d = '0;
        end else begin
            if (fill_done && line_held) begin
                tmr_d.armed = 1'b1;
            end
            if (count_en && !tmr_q.armed) begin
                if (tmr_q.cnt == LAST) begin
                    tmr_d.armed = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign armed = tmr_q.armed;

endmodule

// File: rtl/ewb_sequencer.sv
module ewb_sequencer
    import ewb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_we,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              dn_done,
    input  logic [LINE_W-1:0] dn_rdata,
    input  logic              buf_valid,
    input  logic              buf_hit,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [LINE_W-1:0] buf_data,
    input  logic              armed,
    output logic              cap_en,
    output logic              merge_en,
    output logic              clr_en,
    output logic              fill_done,
    output logic              count_en,
    output logic              up_done,
    output logic [LINE_W-1:0] up_rdata,
    output logic              dn_rd,
    output logic              dn_wr,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [LINE_W-1:0] dn_wdata
);

    typedef struct packed {
        sq_state_t         st;
        logic [LINE_W-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        cap_en    = 1'b0;
        merge_en  = 1'b0;
        clr_en    = 1'b0;
        fill_done = 1'b0;
        count_en  = 1'b0;
        unique case (seq_q.st)
            SQ_IDLE: begin
                count_en = buf_valid;
                if (up_req && buf_hit) begin
                    // request targets the held line: serve it locally
                    if (up_we) begin
                        merge_en = 1'b1;
                    end else begin
                        seq_d.rdata = buf_data;
                    end
                    seq_d.st = SQ_ACK;
                end else if (buf_valid && armed) begin
                    seq_d.st = SQ_DRAIN;
                end else if (up_req && !up_we) begin
                    seq_d.st = SQ_FILL;
                end else if (up_req && up_we && !buf_valid) begin
                    cap_en   = 1'b1;
                    seq_d.st = SQ_ACK;
                end
            end
            SQ_FILL: begin
                if (dn_done) begin
                    fill_done   = 1'b1;
                    seq_d.rdata = dn_rdata;
                    seq_d.st    = SQ_ACK;
                end
            end
            SQ_DRAIN: begin
                if (dn_done) begin
                    clr_en   = 1'b1;
                    seq_d.st = SQ_IDLE;
                end
            end
            SQ_ACK: begin
                seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, rdata: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign up_done  = (seq_q.st == SQ_ACK);
    assign up_rdata = seq_q.rdata;
    assign dn_rd    = (seq_q.st == SQ_FILL);
    assign dn_wr    = (seq_q.st == SQ_DRAIN);
    assign dn_addr  = (seq_q.st == SQ_DRAIN) ? buf_addr : up_addr;
    assign dn_wdata = buf_data;

    // R9
    dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_rd && dn_wr));

    // R9
    dn_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dn_rd || dn_wr) && !dn_done) |=> ((dn_rd || dn_wr) && $stable(dn_addr)));

    // R10
    up_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |=> !up_done);

endmodule

// File: rtl/evict_write_buffer.sv
module evict_write_buffer #(
    parameter int ADDR_W      = 12,
    parameter int LINE_W      = 128,
    parameter int HOLD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_we,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [LINE_W-1:0] up_wdata,
    output logic              up_done,
    output logic [LINE_W-1:0] up_rdata,
    output logic              dn_rd,
    output logic              dn_wr,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [LINE_W-1:0] dn_wdata,
    input  logic              dn_done,
    input  logic [LINE_W-1:0] dn_rdata,
    output logic              wb_empty
);

    logic              cap_en, merge_en, clr_en, fill_done, count_en;
    logic              buf_valid, buf_hit, armed;
    logic [ADDR_W-1:0] buf_addr;
    logic [LINE_W-1:0] buf_data;

    ewb_store #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .merge_en (merge_en),
        .clr_en   (clr_en),
        .in_addr  (up_addr),
        .in_data  (up_wdata),
        .valid    (buf_valid),
        .addr     (buf_addr),
        .data     (buf_data),
        .hit      (buf_hit)
    );

    ewb_arm_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cap_en | clr_en),
        .fill_done (fill_done),
        .line_held (buf_valid),
        .count_en  (count_en),
        .armed     (armed)
    );

    ewb_sequencer #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (up_req),
        .up_we     (up_we),
        .up_addr   (up_addr),
        .dn_done   (dn_done),
        .dn_rdata  (dn_rdata),
        .buf_valid (buf_valid),
        .buf_hit   (buf_hit),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .armed     (armed),
        .cap_en    (cap_en),
        .merge_en  (merge_en),
        .clr_en    (clr_en),
        .fill_done (fill_done),
        .count_en  (count_en),
        .up_done   (up_done),
        .up_rdata  (up_rdata),
        .dn_rd     (dn_rd),
        .dn_wr     (dn_wr),
        .dn_addr   (dn_addr),
        .dn_wdata  (dn_wdata)
    );

    assign wb_empty = !buf_valid;

    // R4
    drain_has_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_wr |-> !wb_empty);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (wb_empty && !up_done && !dn_rd && !dn_wr));

endmodule

// File: tb/evict_write_buffer_test.sv
module evict_write_buffer_test;

    localparam int AW   = 12;
    localparam int LW   = 128;
    localparam int HOLD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0, up_we = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [LW-1:0] up_wdata = '0;
    logic          up_done;
    logic [LW-1:0] up_rdata;
    logic          dn_rd, dn_wr;
    logic [AW-1:0] dn_addr;
    logic [LW-1:0] dn_wdata;
    logic          dn_done = 1'b0;
    logic [LW-1:0] dn_rdata = '0;
    logic          wb_empty;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    evict_write_buffer #(.ADDR_W(AW), .LINE_W(LW), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_done(up_done), .up_rdata(up_rdata),
        .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_done(dn_done), .dn_rdata(dn_rdata), .wb_empty(wb_empty)
    );

    // ---------------- memory model and transaction log ----------------
    logic [LW-1:0] mem [int unsigned];
    logic          log_we   [$];
    logic [AW-1:0] log_addr [$];
    logic [LW-1:0] log_data [$];
    int            lat_cnt = 0;

    function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
        return {4{20'hC3A00, a}};
    endfunction

    function automatic logic [LW-1:0] mem_get(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        dn_done <= 1'b0;
        if ((dn_rd || dn_wr) && !dn_done) begin
            if (lat_cnt == 3) begin
                lat_cnt <= 0;
                dn_done <= 1'b1;
                log_we.push_back(dn_wr);
                log_addr.push_back(dn_addr);
                if (dn_wr) begin
                    mem[int'(dn_addr)] = dn_wdata;
                    log_data.push_back(dn_wdata);
                end else begin
                    dn_rdata <= mem_get(dn_addr);
                    log_data.push_back(mem_get(dn_addr));
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [LW-1:0] exp_q [$];
    string         tag_q [$];
    int            done_dbl = 0;
    int            strobe_clash = 0;
    logic          prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dn_rd && dn_wr) strobe_clash++;
            if (up_done && prev_done) done_dbl++;
            if (up_done && up_req && !up_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected read completion", up_rdata, '0);
                end else begin
                    logic [LW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(up_rdata === e, t, "read data", up_rdata, e);
                end
            end
            prev_done = up_done;
        end
    end

    // driver: issue one cache request and wait for its completion
    task automatic cache_op(input logic we, input logic [AW-1:0] a,
                            input logic [LW-1:0] d, input string tag);
        if (!we) begin
            exp_q.push_back(d);
            tag_q.push_back(tag);
        end
        up_req   = 1'b1;
        up_we    = we;
        up_addr  = a;
        up_wdata = d;
        @(negedge clk);
        while (!up_done) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        up_req = 1'b0;
        up_we  = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 200; i++) begin
            if (wb_empty) break;
            @(negedge clk);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int n0;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!up_done && !dn_rd && !dn_wr && wb_empty, "R1", "reset outputs",
              {up_done, dn_rd, dn_wr, wb_empty}, 4'b0001);

        // R2 capture a victim into the empty slot
        cache_op(1'b1, 12'h010, 128'hAAAA_0010, "R2");
        check(!wb_empty, "R2", "slot holds victim", wb_empty, 0);
        check(log_we.size() == 0, "R2", "no memory access on capture", log_we.size(), 0);

        // R3 fill read goes to memory before the victim write
        cache_op(1'b0, 12'h020, pat(12'h020), "R3");
        check(log_we.size() == 1 && log_we[0] == 1'b0 && log_addr[0] == 12'h020,
              "R3", "first memory access is the fill read", log_addr[0], 12'h020);

        // R4 drain follows the fill
        wait_empty();
        check(wb_empty, "R4", "slot empties after drain", wb_empty, 1);
        check(log_we.size() == 2 && log_we[1] == 1'b1 && log_addr[1] == 12'h010,
              "R4", "second access writes victim", log_addr[1], 12'h010);
        check(mem_get(12'h010) == 128'hAAAA_0010, "R4", "victim data in memory",
              mem_get(12'h010), 128'hAAAA_0010);

        // R5 read hit served from the slot
        cache_op(1'b1, 12'h030, 128'h1111_0030, "R5");
        n0 = log_we.size();
        cache_op(1'b0, 12'h030, 128'h1111_0030, "R5");
        check(log_we.size() == n0, "R5", "read hit made no memory access", log_we.size(), n0);

        // R6 write hit replaces held data
        cache_op(1'b1, 12'h030, 128'h2222_0030, "R6");
        cache_op(1'b0, 12'h030, 128'h2222_0030, "R6");
        check(log_we.size() == n0, "R6", "write hit made no memory access", log_we.size(), n0);
        wait_empty();
        check(mem_get(12'h030) == 128'h2222_0030, "R6", "drain carries merged data",
              mem_get(12'h030), 128'h2222_0030);

        // R8 orphaned line drains after the hold window
        cache_op(1'b1, 12'h040, 128'h4444_0040, "R8");
        gap = 0;
        while (!dn_wr && gap < 200) begin
            @(negedge clk);
            gap++;
        end
        check(gap >= HOLD && gap <= HOLD + 4, "R8", "cycles until drain", gap, HOLD + 2);
        wait_empty();
        check(mem_get(12'h040) == 128'h4444_0040, "R8", "orphan data in memory",
              mem_get(12'h040), 128'h4444_0040);

        // R7 second eviction waits behind the drain that a fill armed
        cache_op(1'b1, 12'h050, 128'h5555_0050, "R7");
        cache_op(1'b0, 12'h060, pat(12'h060), "R3");
        cache_op(1'b1, 12'h070, 128'h7777_0070, "R7");
        check(log_we[log_we.size()-1] == 1'b1 && log_addr[log_addr.size()-1] == 12'h050,
              "R7", "held line written before new capture", log_addr[log_addr.size()-1], 12'h050);
        check(!wb_empty, "R7", "new victim captured", wb_empty, 0);

        // R7 second eviction with no fill waits for the timed drain
        wait_empty();
        cache_op(1'b1, 12'h080, 128'h8888_0080, "R7");
        cache_op(1'b1, 12'h090, 128'h9999_0090, "R7");
        check(log_addr[log_addr.size()-1] == 12'h080 && log_we[log_we.size()-1] == 1'b1,
              "R7", "blocked write followed drain", log_addr[log_addr.size()-1], 12'h080);
        wait_empty();
        check(mem_get(12'h090) == 128'h9999_0090, "R7", "second victim drained",
              mem_get(12'h090), 128'h9999_0090);

        // R9 / R10 protocol monitors
        check(strobe_clash == 0, "R9", "read and write strobes together", strobe_clash, 0);
        check(done_dbl == 0, "R10", "completion pulse longer than one cycle", done_dbl, 0);
        check(exp_q.size() == 0, "R5", "outstanding expected reads", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule